// File: doc/BRIEF.md
# Dual Output Compare Unit

This block sits beside an 8-bit timer counter and watches its value through two independent compare channels. Each channel holds a compare value loaded by the processor. Whenever the counter equals that value, the channel raises a match line for a downstream waveform generator. It also records the event in a sticky flag.

A flag is not set in the cycle the equality is seen. The equality is remembered and written into the flag at the next timer tick after the match cycle. This holds even if the timer-clock enable stays low for a while, because the pending event is kept until a tick arrives.

Each flag can be cleared in two ways: by the interrupt controller's acknowledge, or by software writing a one to the flag's bit in a clear strobe. When an interrupt enable is set, the flag is visible as an interrupt request. If a set and a clear of the same flag fall in the same cycle, the set wins.

Top module: `dual_compare_unit`

## Requirements
- R1: After reset both compare registers read 0, both flags are clear and both interrupt requests are low.
- R2: When `cmpWrEn` is high, `cmpWrData` is loaded at the clock edge into the channel picked by `cmpWrSel` (0 selects channel A, 1 selects channel B). The other channel's register is unchanged.
- R3: `matchOut[i]` is high in the same cycle whenever `cntVal` equals channel i's compare register, whatever the state of `tickEn` (bit 0 is channel A, bit 1 is channel B).
- R4: A match seen in a cycle sets the flag at the edge ending the first later cycle in which `tickEn` is high. It never sets the flag in the match cycle itself.
- R5: A match seen while `tickEn` is low stays pending across any number of low-enable cycles. It is recorded in the flag when `tickEn` next goes high.
- R6: A set flag stays set after the match has gone, until a clear occurs.
- R7: `intAck[i]` high clears flag i at the clock edge.
- R8: With `flagClrEn` high, a one in `flagClrData[i]` clears flag i. A zero in that bit leaves the flag unchanged.
- R9: When a flag set and a clear of the same flag occur in the same cycle, the flag ends set.
- R10: `irqOut[i]` is high exactly when flag i is set and `intEn[i]` is high.
- R11: The two channels are independent: a match, write or clear on one channel never changes the other channel's register or flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tickEn | input | 1 | Timer-clock enable, one cycle per timer tick |
| cntVal | input | 8 | Current counter value |
| cmpWrEn | input | 1 | Compare register write strobe |
| cmpWrSel | input | 1 | Channel selected for the write (0 = A, 1 = B) |
| cmpWrData | input | 8 | Value written to the compare register |
| flagClrEn | input | 1 | Software flag-clear strobe |
| flagClrData | input | 2 | Per-channel clear bits, a one clears |
| intEn | input | 2 | Per-channel interrupt enable |
| intAck | input | 2 | Per-channel interrupt acknowledge |
| matchOut | output | 2 | Per-channel equality to waveform generator |
| flagOut | output | 2 | Per-channel sticky compare flag |
| irqOut | output | 2 | Per-channel interrupt request |
| cmpRegOut | output | 16 | Compare registers, A in bits 7:0, B in bits 15:8 |

## Verification
The hardest situations to reach are the timing edges of the deferred flag set. One is a match held pending through several low-enable cycles. The other is a clear that arrives in the very tick that records a pending match. The stimulus creates both on purpose. It parks the counter on a compare value for a single cycle with the enable low, then idles before raising the enable. It also places a match one cycle ahead of a tick that carries both an acknowledge and a software clear for the same channel. A long sweep of counter values with an irregular enable pattern and scattered clears then mixes these cases on both channels at once.

// File: rtl/ocu_pkg.sv
package ocu_pkg;
  localparam int CH_NUM = 2;
  localparam int SEL_W  = (CH_NUM > 1) ? $clog2(CH_NUM) : 1;

  // Strobes from control to datapath, one bit per channel
  typedef struct packed {
    logic [CH_NUM-1:0] cmpWr;
    logic [CH_NUM-1:0] flagSet;
    logic [CH_NUM-1:0] flagClr;
  } ocuStrb_t;
endpackage

// File: rtl/ocu_ctrl.sv
module ocu_ctrl
  import ocu_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  logic [CH_NUM-1:0] matchVec,
  input  logic              cmpWrEn,
  input  logic [SEL_W-1:0]  cmpWrSel,
  input  logic              flagClrEn,
  input  logic [CH_NUM-1:0] flagClrData,
  input  logic [CH_NUM-1:0] intAck,
  output ocuStrb_t          strb
);

  // One pending bit per channel: a match waiting for the next tick
  logic [CH_NUM-1:0] pendQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendQ <= '0;
    end else begin
      for (int ch = 0; ch < CH_NUM; ch++) begin
        if (tickEn) pendQ[ch] <= matchVec[ch];
        else        pendQ[ch] <= pendQ[ch] | matchVec[ch];
      end
    end
  end

  always_comb begin
    for (int ch = 0; ch < CH_NUM; ch++) begin
      strb.cmpWr[ch]   = cmpWrEn && (cmpWrSel == SEL_W'(ch));
      strb.flagSet[ch] = tickEn && pendQ[ch];
      strb.flagClr[ch] = intAck[ch] || (flagClrEn && flagClrData[ch]);
    end
  end

  generate
    for (genvar g = 0; g < CH_NUM; g++) begin : g_chk
      // R4: a flag set is only issued on a timer tick
      assert_set_on_tick_R4: assert property (@(posedge clk) disable iff (!rstN)
        strb.flagSet[g] |-> tickEn);
      // R5: a match during a low enable is remembered
      assert_pend_held_R5: assert property (@(posedge clk) disable iff (!rstN)
        (matchVec[g] && !tickEn) |=> pendQ[g]);
      // R5: a pending match survives idle cycles
      assert_pend_keep_R5: assert property (@(posedge clk) disable iff (!rstN)
        (pendQ[g] && !tickEn) |=> pendQ[g]);
      // R2: only the selected channel receives a write
      assert_wr_select_R2: assert property (@(posedge clk) disable iff (!rstN)
        $onehot0(strb.cmpWr));
    end
  endgenerate

endmodule

// File: rtl/ocu_datapath.sv
module ocu_datapath
  import ocu_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  ocuStrb_t                 strb,
  input  logic [CNT_W-1:0]         cmpWrData,
  input  logic [CNT_W-1:0]         cntVal,
  input  logic [CH_NUM-1:0]        intEn,
  output logic [CH_NUM-1:0]        matchVec,
  output logic [CH_NUM-1:0]        flagVec,
  output logic [CH_NUM-1:0]        irqVec,
  output logic [CH_NUM*CNT_W-1:0]  cmpRegFlat
);

  logic [CNT_W-1:0] cmpReg [CH_NUM];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int ch = 0; ch < CH_NUM; ch++) cmpReg[ch] <= '0;
    end else begin
      for (int ch = 0; ch < CH_NUM; ch++)
        if (strb.cmpWr[ch]) cmpReg[ch] <= cmpWrData;
    end
  end

  // Set has priority over clear
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flagVec <= '0;
    end else begin
      for (int ch = 0; ch < CH_NUM; ch++) begin
        if (strb.flagSet[ch])      flagVec[ch] <= 1'b1;
        else if (strb.flagClr[ch]) flagVec[ch] <= 1'b0;
      end
    end
  end

  generate
    for (genvar g = 0; g < CH_NUM; g++) begin : g_ch
      assign matchVec[g] = (cntVal == cmpReg[g]);
      assign irqVec[g]   = flagVec[g] & intEn[g];
      assign cmpRegFlat[g*CNT_W +: CNT_W] = cmpReg[g];

      // R2: a write lands the data on the selected channel
      assert_wr_load_R2: assert property (@(posedge clk) disable iff (!rstN)
        strb.cmpWr[g] |=> (cmpReg[g] == $past(cmpWrData)));
      // R11: an unselected register keeps its value
      assert_reg_keep_R11: assert property (@(posedge clk) disable iff (!rstN)
        !strb.cmpWr[g] |=> $stable(cmpReg[g]));
      // R4: a flag only rises after a set strobe
      assert_rise_cause_R4: assert property (@(posedge clk) disable iff (!rstN)
        $rose(flagVec[g]) |-> $past(strb.flagSet[g]));
      // R9: set wins over a clear in the same cycle
      assert_set_wins_R9: assert property (@(posedge clk) disable iff (!rstN)
        strb.flagSet[g] |=> flagVec[g]);
      // R7: a clear without a set empties the flag
      assert_clear_R7: assert property (@(posedge clk) disable iff (!rstN)
        (strb.flagClr[g] && !strb.flagSet[g]) |=> !flagVec[g]);
      // R6: a set flag stays set with no clear
      assert_sticky_R6: assert property (@(posedge clk) disable iff (!rstN)
        (flagVec[g] && !strb.flagClr[g]) |=> flagVec[g]);
      // R10: a request needs its enable
      assert_irq_gate_R10: assert property (@(posedge clk) disable iff (!rstN)
        irqVec[g] |-> (intEn[g] && flagVec[g]));
    end
  endgenerate

endmodule

// File: rtl/dual_compare_unit.sv
module dual_compare_unit
  import ocu_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     tickEn,
  input  logic [CNT_W-1:0]         cntVal,
  input  logic                     cmpWrEn,
  input  logic [SEL_W-1:0]         cmpWrSel,
  input  logic [CNT_W-1:0]         cmpWrData,
  input  logic                     flagClrEn,
  input  logic [CH_NUM-1:0]        flagClrData,
  input  logic [CH_NUM-1:0]        intEn,
  input  logic [CH_NUM-1:0]        intAck,
  output logic [CH_NUM-1:0]        matchOut,
  output logic [CH_NUM-1:0]        flagOut,
  output logic [CH_NUM-1:0]        irqOut,
  output logic [CH_NUM*CNT_W-1:0]  cmpRegOut
);

  ocuStrb_t          strb;
  logic [CH_NUM-1:0] matchVec;

  ocu_ctrl ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .tickEn     (tickEn),
    .matchVec   (matchVec),
    .cmpWrEn    (cmpWrEn),
    .cmpWrSel   (cmpWrSel),
    .flagClrEn  (flagClrEn),
    .flagClrData(flagClrData),
    .intAck     (intAck),
    .strb       (strb)
  );

  ocu_datapath #(.CNT_W(CNT_W)) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .cmpWrData (cmpWrData),
    .cntVal    (cntVal),
    .intEn     (intEn),
    .matchVec  (matchVec),
    .flagVec   (flagOut),
    .irqVec    (irqOut),
    .cmpRegFlat(cmpRegOut)
  );

  assign matchOut = matchVec;

  // R1: state is clear while reset is held
  always @(posedge clk) begin
    if (!rstN) begin
      assert_reset_state_R1: assert (flagOut == '0 && cmpRegOut == '0);
    end
  end

endmodule

// File: tb/dual_compare_unit_tb_top.sv
module dual_compare_unit_tb_top;
  localparam int CLK_PERIOD = 10;

  typedef struct {
    logic [1:0] flag;
    logic [1:0] irq;
    logic [7:0] regA;
    logic [7:0] regB;
    string      tag;
  } expItem_t;

  logic       clk = 0;
  logic       rstN = 0;
  logic       tickEn = 0;
  logic [7:0] cntVal = 8'h01;
  logic       cmpWrEn = 0;
  logic       cmpWrSel = 0;
  logic [7:0] cmpWrData = 0;
  logic       flagClrEn = 0;
  logic [1:0] flagClrData = 0;
  logic [1:0] intEn = 0;
  logic [1:0] intAck = 0;
  logic [1:0] matchOut, flagOut, irqOut;
  logic [15:0] cmpRegOut;

  int checks = 0;
  int failures = 0;
  expItem_t expQ[$];

  // Reference state derived from the requirements
  logic [7:0] mReg [2];
  logic [1:0] mFlag = 0;
  logic [1:0] mPend = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_compare_unit dut_i (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .cntVal(cntVal),
    .cmpWrEn(cmpWrEn), .cmpWrSel(cmpWrSel), .cmpWrData(cmpWrData),
    .flagClrEn(flagClrEn), .flagClrData(flagClrData), .intEn(intEn),
    .intAck(intAck), .matchOut(matchOut), .flagOut(flagOut),
    .irqOut(irqOut), .cmpRegOut(cmpRegOut)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // Driver: apply one cycle of stimulus, update the reference, push the result
  task automatic step(input logic tk, input logic [7:0] cv,
                      input logic we, input logic ws, input logic [7:0] wd,
                      input logic ce, input logic [1:0] cd, input logic [1:0] ak,
                      input string tag);
    logic [1:0] mMatch;
    logic [1:0] nFlag;
    expItem_t it;
    @(negedge clk); #1;
    tickEn = tk; cntVal = cv; cmpWrEn = we; cmpWrSel = ws; cmpWrData = wd;
    flagClrEn = ce; flagClrData = cd; intAck = ak;
    #1;
    for (int i = 0; i < 2; i++) mMatch[i] = (cv == mReg[i]);
    chk("R3 match", {14'b0, matchOut}, {14'b0, mMatch});
    for (int i = 0; i < 2; i++) begin
      if (tk && mPend[i])              nFlag[i] = 1'b1;
      else if (ak[i] || (ce && cd[i])) nFlag[i] = 1'b0;
      else                             nFlag[i] = mFlag[i];
      mPend[i] = tk ? mMatch[i] : (mPend[i] | mMatch[i]);
    end
    mFlag = nFlag;
    if (we) mReg[ws] = wd;
    it.flag = mFlag; it.irq = mFlag & intEn;
    it.regA = mReg[0]; it.regB = mReg[1]; it.tag = tag;
    expQ.push_back(it);
    @(posedge clk); #2;
  endtask

  task automatic idle(input logic tk, input logic [7:0] cv, input string tag);
    step(tk, cv, 0, 0, 8'h00, 0, 2'b00, 2'b00, tag);
  endtask

  // Monitor: compare registered outputs after each edge
  always begin
    @(posedge clk); #1;
    if (expQ.size() > 0) begin
      expItem_t it;
      it = expQ.pop_front();
      chk({it.tag, " flag"}, {14'b0, flagOut}, {14'b0, it.flag});
      chk({it.tag, " irq R10"}, {14'b0, irqOut}, {14'b0, it.irq});
      chk({it.tag, " regs R2"}, cmpRegOut, {it.regB, it.regA});
    end
  end

  initial begin
    #(CLK_PERIOD*100000);
    checks++; failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    mReg[0] = 0; mReg[1] = 0;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 flags", {14'b0, flagOut}, 16'h0);
    chk("R1 irq", {14'b0, irqOut}, 16'h0);
    chk("R1 regs", cmpRegOut, 16'h0000);
    @(negedge clk); rstN = 1;

    step(0, 8'h01, 1, 0, 8'h35, 0, 2'b00, 2'b00, "R2");
    chk("R2 write A", cmpRegOut, 16'h0035);
    step(0, 8'h01, 1, 1, 8'hC0, 0, 2'b00, 2'b00, "R2");
    chk("R2 write B", cmpRegOut, 16'hC035);

    idle(1, 8'h35, "R3");
    chk("R4 no set in match cycle", {14'b0, flagOut}, 16'h0);
    idle(1, 8'h36, "R4");
    chk("R4 set next tick", {14'b0, flagOut}, 16'h1);
    for (int i = 0; i < 4; i++) idle(1, 8'h37 + 8'(i), "R6");
    chk("R6 sticky", {14'b0, flagOut}, 16'h1);

    intEn = 2'b11;
    idle(1, 8'h10, "R10");
    chk("R10 irq", {14'b0, irqOut}, 16'h1);
    step(1, 8'h10, 0, 0, 0, 0, 2'b00, 2'b01, "R7");
    chk("R7 ack clears", {14'b0, flagOut}, 16'h0);

    idle(0, 8'hC0, "R5");
    for (int i = 0; i < 3; i++) idle(0, 8'h10, "R5");
    chk("R5 held while idle", {14'b0, flagOut}, 16'h0);
    idle(1, 8'h10, "R5");
    chk("R5 recorded on tick", {14'b0, flagOut}, 16'h2);

    step(1, 8'h10, 0, 0, 0, 1, 2'b00, 2'b00, "R8");
    chk("R8 zero bits no effect", {14'b0, flagOut}, 16'h2);
    step(1, 8'h10, 0, 0, 0, 1, 2'b01, 2'b00, "R11");
    chk("R11 clear A leaves B", {14'b0, flagOut}, 16'h2);
    step(1, 8'h10, 0, 0, 0, 1, 2'b10, 2'b00, "R8");
    chk("R8 one bit clears", {14'b0, flagOut}, 16'h0);

    idle(1, 8'h35, "R9");
    step(1, 8'h10, 0, 0, 0, 1, 2'b01, 2'b01, "R9");
    chk("R9 set beats clear", {14'b0, flagOut}, 16'h1);

    step(0, 8'h10, 1, 0, 8'h77, 0, 2'b00, 2'b00, "R11");
    step(0, 8'h10, 1, 1, 8'h77, 0, 2'b00, 2'b00, "R11");
    idle(1, 8'h77, "R11");
    idle(1, 8'h78, "R11");
    chk("R11 both channels", {14'b0, flagOut}, 16'h3);

    intEn = 2'b10;
    for (int i = 0; i < 700; i++) begin
      logic tk;
      logic [1:0] ak, cd;
      tk = ((i % 3) == 0) || ((i % 7) == 5);
      ak = ((i % 11) == 0) ? 2'b01 : (((i % 13) == 0) ? 2'b10 : 2'b00);
      cd = ((i % 5) == 2) ? 2'(i / 5) : 2'b00;
      step(tk, 8'(i * 3), (i % 97) == 50, i[0], 8'(i), (i % 5) == 2, cd, ak, "R4 R5 sweep");
    end

    repeat (3) @(posedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule